// File: doc/BRIEF.md
# Dual-Space Memory Address Decoder

This block connects two independent CPU address spaces to a small set of on-chip byte memories. Each space drives its own address, read strobe and write strobe. A space accepts only addresses inside its own legal range, which has a start that need not be zero and a size. Inside that range a list of decode windows maps addresses onto memory chips. Each window has a start address, a size, a target chip and an offset into that chip. All windows are fixed by parameters and are checked at elaboration.

On a hit the block enables one chip and turns the bus address into a cell index for that chip. A chip may be reached from both spaces. The strobes of the two spaces are merged into the single write control of that chip, and the two read paths share its storage. Accesses that match no window are absorbed: writes change nothing, and reads return a fixed pull value. When both spaces touch the same chip in one cycle, space 0 wins. The access from space 1 is dropped and flagged.

Top module: `mspace_decoder`

## Requirements
- R1: An address hits a window when window_start <= addr < window_start + window_size. The cell it reaches in the target chip is addr - window_start + window_offset.
- R2: When several windows of one space match an address, the lowest-numbered window decides the chip and the cell.
- R3: An address outside its space's legal range (space_start <= addr < space_start + space_size) is undecoded, even if a window covers it.
- R4: A write to an undecoded address leaves the contents of every chip unchanged.
- R5: A read from an undecoded address returns PULL_VALUE (default 8'hFF) on that space's read data one clock later.
- R6: Read data is registered. It appears one clock after the read strobe is sampled. In a cycle that follows no successful read, the read data shows PULL_VALUE.
- R7: A write lands at the clock edge that samples the write strobe. A read of the same cell in the same cycle returns the contents from before that write.
- R8: A single access of one space enables at most one chip.
- R9: A chip mapped into both spaces is one store: data written through one space can be read through the other.
- R10: If both spaces access the same chip in one cycle, space 0 proceeds. The space 1 access has no effect, its read data shows PULL_VALUE, and s1_conflict is 1 one clock later. Otherwise s1_conflict is 0.
- R11: While reset is active, and after it is released, both read data outputs hold PULL_VALUE and s1_conflict is 0.
- R12: Elaboration fails for a window whose offset plus size exceeds CHIP_DEPTH, or whose target chip does not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_addr | input | ADDR_W | Space 0 address |
| s0_rd | input | 1 | Space 0 read strobe |
| s0_wr | input | 1 | Space 0 write strobe |
| s0_wdata | input | DATA_W | Space 0 write data |
| s0_rdata | output | DATA_W | Space 0 registered read data |
| s1_addr | input | ADDR_W | Space 1 address |
| s1_rd | input | 1 | Space 1 read strobe |
| s1_wr | input | 1 | Space 1 write strobe |
| s1_wdata | input | DATA_W | Space 1 write data |
| s1_rdata | output | DATA_W | Space 1 registered read data |
| s1_conflict | output | 1 | Space 1 lost arbitration in the previous cycle |

## Verification
The bench builds the block with its default parameters: two 16-entry chips, two windows per space, and PULL_VALUE 8'hFF. Space 0 has the legal range 0x1000 to 0x1009. Its window 0 maps 0x1000 to 0x1007 onto chip 0 cells 0 to 7. Its window 1 starts at 0x1004 and runs to 0x100B on chip 1, so it overlaps window 0 and also runs past the end of the space's range. Space 1 maps 0x2000 to 0x2003 onto chip 0 cells 4 to 7, and 0x2010 to 0x2017 onto chip 1 cells 8 to 15. This map makes it possible to observe overlap priority, range clipping, shared cells, cells that no address reaches, and same-chip contention between the spaces.

// File: rtl/mspace_pkg.sv
package mspace_pkg;
   localparam int unsigned FIELD_W    = 32;
   localparam int unsigned NUM_SPACES = 2;
   typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/msd_win_match.sv
module msd_win_match
   import mspace_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_WIN   = 2,
   parameter int unsigned NUM_CHIPS = 2,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned CHIP_W    = 1,
   parameter int unsigned IDX_W     = 4,
   parameter logic [NUM_WIN*FIELD_W-1:0] W_START  = '0,
   parameter logic [NUM_WIN*FIELD_W-1:0] W_SIZE   = '0,
   parameter logic [NUM_WIN*FIELD_W-1:0] W_CHIP   = '0,
   parameter logic [NUM_WIN*FIELD_W-1:0] W_OFFSET = '0,
   parameter field_t SP_START = '0,
   parameter field_t SP_SIZE  = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [CHIP_W-1:0] chip,
   output logic [IDX_W-1:0]  idx
);
   // elaboration-time checks on the window table
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
      if (W_OFFSET[w*FIELD_W +: FIELD_W] + W_SIZE[w*FIELD_W +: FIELD_W] > DEPTH) begin : g_bad_range
         $error("window %0d runs past the end of its chip", w);
      end
      if (W_CHIP[w*FIELD_W +: FIELD_W] >= NUM_CHIPS) begin : g_bad_chip
         $error("window %0d targets a missing chip", w);
      end
   end

   field_t addr_ext;
   field_t rel;
   logic   in_space;

   always_comb begin
      addr_ext = '0;
      addr_ext[ADDR_W-1:0] = addr;
      in_space = (addr_ext >= SP_START) && ((addr_ext - SP_START) < SP_SIZE);
   end

   // scan from the top so the lowest matching window is written last
   always_comb begin
      hit  = 1'b0;
      chip = '0;
      idx  = '0;
      rel  = '0;
      if (in_space) begin
         for (int w = NUM_WIN - 1; w >= 0; w--) begin
            rel = addr_ext - W_START[w*FIELD_W +: FIELD_W];
            if (addr_ext >= W_START[w*FIELD_W +: FIELD_W] &&
                rel < W_SIZE[w*FIELD_W +: FIELD_W]) begin
               hit  = 1'b1;
               chip = CHIP_W'(W_CHIP[w*FIELD_W +: FIELD_W]);
               idx  = IDX_W'(rel + W_OFFSET[w*FIELD_W +: FIELD_W]);
            end
         end
      end
   end
endmodule

// File: rtl/msd_chip_array.sv
module msd_chip_array #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  ridx_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[widx] <= wdata;
   end

   assign rdata_a = cells[ridx_a];
   assign rdata_b = cells[ridx_b];
endmodule

// File: rtl/mspace_decoder.sv
module mspace_decoder
   import mspace_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_CHIPS  = 2,
   parameter int unsigned CHIP_DEPTH = 16,
   parameter int unsigned NUM_WIN    = 2,
   parameter logic [DATA_W-1:0] PULL_VALUE = 8'hFF,
   // per space, NUM_WIN fields of FIELD_W bits; space 0 in the low half
   parameter logic [NUM_SPACES*NUM_WIN*FIELD_W-1:0] WIN_START  = {32'h2010, 32'h2000, 32'h1004, 32'h1000},
   parameter logic [NUM_SPACES*NUM_WIN*FIELD_W-1:0] WIN_SIZE   = {32'd8, 32'd4, 32'd8, 32'd8},
   parameter logic [NUM_SPACES*NUM_WIN*FIELD_W-1:0] WIN_CHIP   = {32'd1, 32'd0, 32'd1, 32'd0},
   parameter logic [NUM_SPACES*NUM_WIN*FIELD_W-1:0] WIN_OFFSET = {32'd8, 32'd4, 32'd0, 32'd0},
   parameter logic [NUM_SPACES*FIELD_W-1:0] SPACE_START = {32'h2000, 32'h1000},
   parameter logic [NUM_SPACES*FIELD_W-1:0] SPACE_SIZE  = {32'h100, 32'h00A}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s0_addr,
   input  logic              s0_rd,
   input  logic              s0_wr,
   input  logic [DATA_W-1:0] s0_wdata,
   output logic [DATA_W-1:0] s0_rdata,
   input  logic [ADDR_W-1:0] s1_addr,
   input  logic              s1_rd,
   input  logic              s1_wr,
   input  logic [DATA_W-1:0] s1_wdata,
   output logic [DATA_W-1:0] s1_rdata,
   output logic              s1_conflict
);
   localparam int unsigned CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
   localparam int unsigned IDX_W  = $clog2(CHIP_DEPTH);
   localparam int unsigned SPAN   = NUM_WIN * FIELD_W;

   if (ADDR_W > FIELD_W || ADDR_W == 0) begin : g_bad_addr
      $error("ADDR_W must lie in 1..%0d", FIELD_W);
   end
   if (CHIP_DEPTH < 2 || NUM_CHIPS == 0 || NUM_WIN == 0) begin : g_bad_shape
      $error("need CHIP_DEPTH >= 2 and at least one chip and one window");
   end

   logic [ADDR_W-1:0] sp_addr [NUM_SPACES];
   logic              sp_acc  [NUM_SPACES];
   logic              sp_hit  [NUM_SPACES];
   logic [CHIP_W-1:0] sp_chip [NUM_SPACES];
   logic [IDX_W-1:0]  sp_idx  [NUM_SPACES];

   assign sp_addr[0] = s0_addr;
   assign sp_addr[1] = s1_addr;
   assign sp_acc[0]  = s0_rd | s0_wr;
   assign sp_acc[1]  = s1_rd | s1_wr;

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      msd_win_match #(
         .ADDR_W   (ADDR_W),
         .NUM_WIN  (NUM_WIN),
         .NUM_CHIPS(NUM_CHIPS),
         .DEPTH    (CHIP_DEPTH),
         .CHIP_W   (CHIP_W),
         .IDX_W    (IDX_W),
         .W_START  (WIN_START [s*SPAN +: SPAN]),
         .W_SIZE   (WIN_SIZE  [s*SPAN +: SPAN]),
         .W_CHIP   (WIN_CHIP  [s*SPAN +: SPAN]),
         .W_OFFSET (WIN_OFFSET[s*SPAN +: SPAN]),
         .SP_START (SPACE_START[s*FIELD_W +: FIELD_W]),
         .SP_SIZE  (SPACE_SIZE [s*FIELD_W +: FIELD_W])
      ) u_match (
         .addr (sp_addr[s]),
         .hit  (sp_hit[s]),
         .chip (sp_chip[s]),
         .idx  (sp_idx[s])
      );
   end

   logic [NUM_CHIPS-1:0] en0, en1, gnt1;
   logic [DATA_W-1:0]    rd_word0 [NUM_CHIPS];
   logic [DATA_W-1:0]    rd_word1 [NUM_CHIPS];

   for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
      logic              c_we;
      logic [IDX_W-1:0]  c_widx;
      logic [DATA_W-1:0] c_wdata;

      assign en0[c]  = sp_acc[0] & sp_hit[0] & (sp_chip[0] == CHIP_W'(c));
      assign en1[c]  = sp_acc[1] & sp_hit[1] & (sp_chip[1] == CHIP_W'(c));
      assign gnt1[c] = en1[c] & ~en0[c];

      // both spaces' write strobes merge into this chip's single control
      assign c_we    = (en0[c] & s0_wr) | (gnt1[c] & s1_wr);
      assign c_widx  = en0[c] ? sp_idx[0] : sp_idx[1];
      assign c_wdata = en0[c] ? s0_wdata  : s1_wdata;

      msd_chip_array #(
         .DEPTH  (CHIP_DEPTH),
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_array (
         .clk     (clk),
         .we      (c_we),
         .widx    (c_widx),
         .wdata   (c_wdata),
         .ridx_a  (sp_idx[0]),
         .rdata_a (rd_word0[c]),
         .ridx_b  (sp_idx[1]),
         .rdata_b (rd_word1[c])
      );
   end

   logic clash;
   assign clash = |(en0 & en1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_rdata    <= PULL_VALUE;
         s1_rdata    <= PULL_VALUE;
         s1_conflict <= 1'b0;
      end else begin
         s0_rdata    <= (s0_rd & sp_hit[0]) ? rd_word0[sp_chip[0]] : PULL_VALUE;
         s1_rdata    <= (s1_rd & sp_hit[1] & ~clash) ? rd_word1[sp_chip[1]] : PULL_VALUE;
         s1_conflict <= clash;
      end
   end
endmodule

// File: rtl/msd_checker.sv
module msd_checker #(
   parameter int unsigned NUM_CHIPS = 2,
   parameter int unsigned DATA_W    = 8,
   parameter logic [DATA_W-1:0] PULL_VALUE = 8'hFF
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 s0_rd,
   input logic                 s0_wr,
   input logic                 s1_rd,
   input logic                 s1_wr,
   input logic [NUM_CHIPS-1:0] en0,
   input logic [NUM_CHIPS-1:0] en1,
   input logic [DATA_W-1:0]    s0_rdata,
   input logic [DATA_W-1:0]    s1_rdata,
   input logic                 s1_conflict
);
   assert_one_chip_s0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en0));
   assert_one_chip_s1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en1));
   assert_idle_pull_s0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s0_rd |=> s0_rdata == PULL_VALUE);
   assert_idle_pull_s1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_rd |=> s1_rdata == PULL_VALUE);
   assert_miss_pull_s0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_rd && en0 == '0) |=> s0_rdata == PULL_VALUE);
   assert_clash_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((en0 & en1) != '0) |=> s1_conflict);
   assert_no_idle_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(s1_rd || s1_wr) |=> !s1_conflict);
   assert_loser_pull_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s1_conflict |-> s1_rdata == PULL_VALUE);
endmodule

bind mspace_decoder msd_checker #(
   .NUM_CHIPS  (NUM_CHIPS),
   .DATA_W     (DATA_W),
   .PULL_VALUE (PULL_VALUE)
) u_msd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .s0_rd       (s0_rd),
   .s0_wr       (s0_wr),
   .s1_rd       (s1_rd),
   .s1_wr       (s1_wr),
   .en0         (en0),
   .en1         (en1),
   .s0_rdata    (s0_rdata),
   .s1_rdata    (s1_rdata),
   .s1_conflict (s1_conflict)
);

// File: tb/mspace_decoder_bench.sv
module mspace_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] s0_addr = '0, s1_addr = '0;
   logic        s0_rd = 0, s0_wr = 0, s1_rd = 0, s1_wr = 0;
   logic [7:0]  s0_wdata = '0, s1_wdata = '0;
   logic [7:0]  s0_rdata, s1_rdata;
   logic        s1_conflict;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #4 clk = ~clk;

   mspace_decoder u_mspace_decoder (
      .clk(clk), .rst_n(rst_n),
      .s0_addr(s0_addr), .s0_rd(s0_rd), .s0_wr(s0_wr), .s0_wdata(s0_wdata), .s0_rdata(s0_rdata),
      .s1_addr(s1_addr), .s1_rd(s1_rd), .s1_wr(s1_wr), .s1_wdata(s1_wdata), .s1_rdata(s1_rdata),
      .s1_conflict(s1_conflict)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks begin and end just after a falling edge
   task automatic wr(input int s, input logic [15:0] a, input logic [7:0] d);
      if (s == 0) begin s0_addr = a; s0_wdata = d; s0_wr = 1; end
      else        begin s1_addr = a; s1_wdata = d; s1_wr = 1; end
      @(negedge clk);
      s0_wr = 0; s1_wr = 0;
   endtask

   task automatic rd(input int s, input logic [15:0] a, output logic [7:0] q);
      if (s == 0) begin s0_addr = a; s0_rd = 1; end
      else        begin s1_addr = a; s1_rd = 1; end
      @(negedge clk);
      s0_rd = 0; s1_rd = 0;
      q = (s == 0) ? s0_rdata : s1_rdata;
   endtask

   task automatic rd_chk(input string req, input int s, input logic [15:0] a, input logic [7:0] exp);
      logic [7:0] q;
      rd(s, a, q);
      check(req, q, exp);
   endtask

   task automatic t_reset;
      check("R11 s0_rdata", s0_rdata, 8'hFF);
      check("R11 s1_rdata", s1_rdata, 8'hFF);
      check("R11 conflict", {7'd0, s1_conflict}, 8'h00);
   endtask

   task automatic t_fill_map;
      for (int i = 0; i < 8; i++) wr(0, 16'h1000 + 16'(i), 8'h10 + 8'(i));
      wr(0, 16'h1008, 8'hA8);
      wr(0, 16'h1009, 8'hA9);
      for (int i = 0; i < 8; i++) wr(1, 16'h2010 + 16'(i), 8'hB0 + 8'(i));
      rd_chk("R1 s0 win0 cell3", 0, 16'h1003, 8'h13);
      rd_chk("R1 s0 win1 offset", 0, 16'h1008, 8'hA8);
      rd_chk("R1 s1 win1 offset", 1, 16'h2014, 8'hB4);
      rd_chk("R9 s1 sees chip0 cell6", 1, 16'h2002, 8'h16);
   endtask

   task automatic t_overlap;
      wr(0, 16'h1005, 8'h5C);
      rd_chk("R2 lowest window took write", 1, 16'h2001, 8'h5C);
      rd_chk("R2 higher window cell intact", 0, 16'h1009, 8'hA9);
   endtask

   task automatic t_out_of_space;
      wr(0, 16'h100A, 8'hEE);
      rd_chk("R3 window past space end", 0, 16'h100A, 8'hFF);
      rd_chk("R3 below space start", 0, 16'h0FFF, 8'hFF);
   endtask

   task automatic t_unmapped_write;
      wr(1, 16'h2008, 8'h77);
      wr(1, 16'h2005, 8'h78);
      wr(0, 16'h3000, 8'h79);
      for (int i = 0; i < 8; i++)
         rd_chk("R4 chip0 unchanged", 0, 16'h1000 + 16'(i), (i == 5) ? 8'h5C : 8'h10 + 8'(i));
      for (int i = 0; i < 8; i++)
         rd_chk("R4 chip1 unchanged", 1, 16'h2010 + 16'(i), 8'hB0 + 8'(i));
      rd_chk("R4 chip1 cell5 unchanged", 0, 16'h1009, 8'hA9);
   endtask

   task automatic t_unmapped_read;
      rd_chk("R5 s1 gap between windows", 1, 16'h2005, 8'hFF);
      rd_chk("R5 s1 far address", 1, 16'h0000, 8'hFF);
   endtask

   task automatic t_read_timing;
      logic [7:0] q;
      rd(0, 16'h1002, q);
      check("R6 data one clock after strobe", q, 8'h12);
      @(negedge clk);
      check("R6 idle cycle shows pull", s0_rdata, 8'hFF);
   endtask

   task automatic t_rd_wr_same;
      s0_addr = 16'h1001; s0_wdata = 8'h99; s0_rd = 1; s0_wr = 1;
      @(negedge clk);
      s0_rd = 0; s0_wr = 0;
      check("R7 same-cycle read returns old", s0_rdata, 8'h11);
      rd_chk("R7 write landed", 0, 16'h1001, 8'h99);
   endtask

   task automatic t_contention;
      // write clash on chip0 cell6
      s0_addr = 16'h1006; s0_wdata = 8'h66; s0_wr = 1;
      s1_addr = 16'h2002; s1_wdata = 8'h22; s1_wr = 1;
      @(negedge clk);
      s0_wr = 0; s1_wr = 0;
      check("R10 conflict after write clash", {7'd0, s1_conflict}, 8'h01);
      rd_chk("R10 space0 write won", 1, 16'h2002, 8'h66);
      check("R10 flag clears", {7'd0, s1_conflict}, 8'h00);
      // read clash on chip0
      s0_addr = 16'h1000; s0_rd = 1;
      s1_addr = 16'h2003; s1_rd = 1;
      @(negedge clk);
      s0_rd = 0; s1_rd = 0;
      check("R10 space0 read served", s0_rdata, 8'h10);
      check("R10 space1 read pulled", s1_rdata, 8'hFF);
      check("R10 conflict after read clash", {7'd0, s1_conflict}, 8'h01);
      // R8: each access enables only its own chip, so different chips both complete
      s0_addr = 16'h1000; s0_rd = 1;
      s1_addr = 16'h2010; s1_rd = 1;
      @(negedge clk);
      s0_rd = 0; s1_rd = 0;
      check("R8 space0 on chip0", s0_rdata, 8'h10);
      check("R8 space1 on chip1", s1_rdata, 8'hB0);
      check("R10 no conflict across chips", {7'd0, s1_conflict}, 8'h00);
   endtask

   initial begin
      // R12: the default window table fits its chips, so elaboration proceeds
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_fill_map();
      t_overlap();
      t_out_of_space();
      t_unmapped_write();
      t_unmapped_read();
      t_read_timing();
      t_rd_wr_same();
      t_contention();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule